// File: doc/BRIEF.md
# Five-State Sequence Counter With Recovery

This block is a 3-bit synchronous counter with state bits C (most significant), B and A (least significant). When enabled it steps through a fixed loop of five codes instead of counting in binary. It suits places where a short repeating sequence of codes is wanted and only five of the eight codes are legal.

The codes 001, 101 and 110 are outside the loop. Each of them still has a fixed successor, so a register that powers up or is disturbed into one of them returns to the loop after at most two enabled clock edges. A combinational flag reports when the register holds one of these spare codes. A synchronous active-high reset loads a code chosen by a parameter. The default is 000, and an integrator can override it. When the count enable is low the register holds its value, whether that value is a loop code or a spare code.

Top module: `penta_seq_ctr`

## Requirements
- R1: On a clock edge with `rst` high, `state` becomes the parameter `RESET_CODE` (default 000), whatever the value of `countEn`.
- R2: With `rst` low and `countEn` high, each edge moves `state` along the loop 000 → 100 → 111 → 010 → 011 → 000, and `spareFlag` stays low throughout the loop.
- R3: With `countEn` high, spare code 001 goes to 111 on the next edge.
- R4: With `countEn` high, spare code 101 goes to 110 on the next edge.
- R5: With `countEn` high, spare code 110 goes to 011 on the next edge.
- R6: With `rst` low and `countEn` low, `state` keeps its value across the edge, including when it holds a spare code.
- R7: `spareFlag` is high in the same cycle as `state`, and only when `state` is 001, 101 or 110.
- R8: From any spare code, at most two enabled edges bring `state` into the loop, after which `spareFlag` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, loads `RESET_CODE` |
| countEn | input | 1 | Advances the state on an edge when high |
| state | output | 3 | Current code, bit 2 = C, bit 1 = B, bit 0 = A |
| spareFlag | output | 1 | High while `state` is one of the three codes outside the loop |

## Verification
The bench builds four copies of the counter. One uses the default reset code 000. The other three have `RESET_CODE` set to 001, 101 and 110 in turn. The block has no load port, so these overrides are the only way to place the register in a spare code through its normal interface. They bring each spare successor, holding in a spare code, and the two-edge path out of 101 within reach. The default copy walks the full loop with idle cycles mixed in and is then reset in the middle of a count.

// File: rtl/penta_seq_pkg.sv
package penta_seq_pkg;

  localparam int CODE_W     = 3;
  localparam int CODE_COUNT = 1 << CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic advance;
  } strobe_t;

  // Successor of each code; spare codes map back toward the loop
  function automatic code_t successor(code_t cur);
    code_t nxt;
    case (cur)
      3'b000:  nxt = 3'b100;
      3'b100:  nxt = 3'b111;
      3'b111:  nxt = 3'b010;
      3'b010:  nxt = 3'b011;
      3'b011:  nxt = 3'b000;
      3'b001:  nxt = 3'b111;
      3'b101:  nxt = 3'b110;
      default: nxt = 3'b011; // 3'b110
    endcase
    return nxt;
  endfunction

  function automatic logic isSpare(code_t cur);
    return (cur == 3'b001) || (cur == 3'b101) || (cur == 3'b110);
  endfunction

endpackage

// File: rtl/penta_seq_ctrl.sv
module penta_seq_ctrl
  import penta_seq_pkg::*;
(
  input  logic    rst,
  input  logic    countEn,
  output strobe_t strobes
);

  always_comb begin
    strobes.clear   = rst;
    strobes.advance = !rst && countEn;
  end

endmodule

// File: rtl/penta_seq_dp.sv
module penta_seq_dp
  import penta_seq_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic    clk,
  input  strobe_t strobes,
  output code_t   stateQ,
  output logic    spareFlag
);

  code_t                 nextTable [CODE_COUNT];
  logic [CODE_COUNT-1:0] spareVec;
  code_t                 stateD;

  for (genvar i = 0; i < CODE_COUNT; i++) begin : g_code
    assign nextTable[i] = successor(code_t'(i));
    assign spareVec[i]  = isSpare(code_t'(i));
  end

  always_comb begin
    if (strobes.clear)        stateD = RESET_CODE;
    else if (strobes.advance) stateD = nextTable[stateQ];
    else                      stateD = stateQ;
  end

  always_ff @(posedge clk) begin
    stateQ <= stateD;
  end

  assign spareFlag = spareVec[stateQ];

endmodule

// File: rtl/penta_seq_ctr.sv
module penta_seq_ctr
  import penta_seq_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              countEn,
  output logic [CODE_W-1:0] state,
  output logic              spareFlag
);

  strobe_t strobes;

  penta_seq_ctrl ctrl_i (
    .rst     (rst),
    .countEn (countEn),
    .strobes (strobes)
  );

  penta_seq_dp #(.RESET_CODE(RESET_CODE)) dp_i (
    .clk       (clk),
    .strobes   (strobes),
    .stateQ    (state),
    .spareFlag (spareFlag)
  );

endmodule

// File: rtl/penta_seq_chk.sv
module penta_seq_chk
  import penta_seq_pkg::*;
#(
  parameter code_t RESET_CODE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              countEn,
  input logic [CODE_W-1:0] state,
  input logic              spareFlag
);

  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> state == RESET_CODE); // R1

  AST_LOOP_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (countEn && !spareFlag) |=> !spareFlag); // R2

  AST_LOOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (countEn && state == 3'b000) |=> state == 3'b100); // R2

  AST_SPARE_ONE: assert property (@(posedge clk) disable iff (rst)
    (countEn && state == 3'b001) |=> state == 3'b111); // R3

  AST_SPARE_FIVE: assert property (@(posedge clk) disable iff (rst)
    (countEn && state == 3'b101) |=> state == 3'b110); // R4

  AST_SPARE_SIX: assert property (@(posedge clk) disable iff (rst)
    (countEn && state == 3'b110) |=> state == 3'b011); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !countEn |=> $stable(state)); // R6

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    spareFlag == (state == 3'b001 || state == 3'b101 || state == 3'b110)); // R7

  AST_TWO_STEP: assert property (@(posedge clk) disable iff (rst)
    (countEn && spareFlag && $past(countEn) && $past(spareFlag) && !$past(rst))
      |=> !spareFlag); // R8

endmodule

bind penta_seq_ctr penta_seq_chk #(.RESET_CODE(RESET_CODE)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .countEn   (countEn),
  .state     (state),
  .spareFlag (spareFlag)
);

// File: tb/penta_seq_ctr_tb_top.sv
`timescale 1ns/1ps
module penta_seq_ctr_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic countEn = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] st0, st1, st5, st6;
  logic       fl0, fl1, fl5, fl6;

  penta_seq_ctr dut_i (.clk(clk), .rst(rst), .countEn(countEn), .state(st0), .spareFlag(fl0));
  penta_seq_ctr #(.RESET_CODE(3'b001)) dutFrom1_i (.clk(clk), .rst(rst), .countEn(countEn), .state(st1), .spareFlag(fl1));
  penta_seq_ctr #(.RESET_CODE(3'b101)) dutFrom5_i (.clk(clk), .rst(rst), .countEn(countEn), .state(st5), .spareFlag(fl5));
  penta_seq_ctr #(.RESET_CODE(3'b110)) dutFrom6_i (.clk(clk), .rst(rst), .countEn(countEn), .state(st6), .spareFlag(fl6));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // {countEn, expected state[2:0], expected spareFlag}
  localparam logic [4:0] VEC [12] = '{
    5'b1_100_0, 5'b1_111_0, 5'b0_111_0, 5'b1_010_0,
    5'b1_011_0, 5'b0_011_0, 5'b1_000_0, 5'b1_100_0,
    5'b1_111_0, 5'b1_010_0, 5'b1_011_0, 5'b1_000_0
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic e);
    @(negedge clk);
    rst = r;
    countEn = e;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0);
    chk("R1 default reset", {st0, fl0}, 4'b000_0);
    chk("R7 reset 001 flag", {st1, fl1}, 4'b001_1);
    chk("R7 reset 101 flag", {st5, fl5}, 4'b101_1);
    chk("R7 reset 110 flag", {st6, fl6}, 4'b110_1);

    for (int i = 0; i < 2; i++) drive(1'b0, 1'b0);
    chk("R6 hold 000", {st0, fl0}, 4'b000_0);
    chk("R6 hold 001", {st1, fl1}, 4'b001_1);
    chk("R6 hold 101", {st5, fl5}, 4'b101_1);
    chk("R6 hold 110", {st6, fl6}, 4'b110_1);

    drive(1'b0, 1'b1);
    chk("R3 001 to 111", {st1, fl1}, 4'b111_0);
    chk("R4 101 to 110", {st5, fl5}, 4'b110_1);
    chk("R5 110 to 011", {st6, fl6}, 4'b011_0);

    drive(1'b0, 1'b1);
    chk("R8 from 001 second edge", {st1, fl1}, 4'b010_0);
    chk("R8 from 101 second edge", {st5, fl5}, 4'b011_0);
    chk("R8 from 110 second edge", {st6, fl6}, 4'b000_0);

    drive(1'b1, 1'b0);
    chk("R1 reset after run", {st0, fl0}, 4'b000_0);
    for (int i = 0; i < 12; i++) begin
      drive(1'b0, VEC[i][4]);
      chk(VEC[i][4] ? "R2 loop step" : "R6 idle hold", {st0, fl0}, VEC[i][3:0]);
    end

    drive(1'b0, 1'b1);
    chk("R2 step before reset", {st0, fl0}, 4'b100_0);
    drive(1'b1, 1'b1);
    chk("R1 reset beats enable", {st0, fl0}, 4'b000_0);
    chk("R1 reset beats enable 101", {st5, fl5}, 4'b101_1);

    finish_run();
  end

endmodule